// File: doc/BRIEF.md
# Trap Return Sequencer

This block executes the two privileged return instructions of a processor core: the return from a machine-level trap and the return from a supervisor-level trap. A single-cycle request carries the return kind together with the current privilege, the machine status word, both saved exception program counters and a flag telling whether compressed instructions are enabled. One cycle later the block presents the updated status word, the privilege to resume in, the resume address and any exception the return raised. It also raises a one-cycle completion pulse. The results then stay on the outputs until the next request.

The block first checks that the return is permitted at the current privilege. It then checks that the resume address is suitably aligned. If both checks pass, it pops the interrupt-enable stack of the returning level and loads the privilege that was saved at trap time. If a check fails, the status word and privilege pass through unchanged and an exception flag with its cause code is raised instead. Trap entry is handled elsewhere.

Privilege encoding throughout: 0 = user, 1 = supervisor, 2 = reserved, 3 = machine. The status word uses the standard bit positions: supervisor enable at bit 1, machine enable at bit 3, supervisor previous-enable at bit 5, machine previous-enable at bit 7, supervisor previous-privilege at bit 8 (one bit), and machine previous-privilege at bits 12:11.

Top module: `trap_return_seq`

## Requirements
- R1: `ret_done` is high in exactly the cycle after each cycle in which `ret_req` is high, and low otherwise.
- R2: A machine return with `cur_priv` not equal to 3, or a supervisor return with `cur_priv` equal to 0, sets `exc_illegal` and gives `exc_cause` = 2.
- R3: `target_pc` is `mepc_in` for a machine return (`ret_is_mret` = 1) and `sepc_in` for a supervisor return.
- R4: When `has_compressed` is 0, the return is legal and bits [1:0] of the resume address are nonzero, `exc_misaligned` is set with `exc_cause` = 0. When `has_compressed` is 1 the address is never flagged. An illegal return never also reports a misaligned one. With no exception, both flags and `exc_cause` are 0.
- R5: On any exception, `status_out` equals the request's `status_in` and `priv_out` equals its `cur_priv`.
- R6: A legal machine return sets bit 3 from bit 7, then clears bit 7 and bits 12:11, and leaves every other status bit unchanged.
- R7: A legal supervisor return sets bit 1 from bit 5, then clears bit 5 and bit 8, and leaves every other status bit unchanged.
- R8: A legal machine return sets `priv_out` to the value of bits 12:11 of `status_in`, except that the reserved value 2 gives 0.
- R9: A legal supervisor return sets `priv_out` to bit 8 of `status_in`, zero-extended.
- R10: Between requests, all result outputs hold their values regardless of input changes. After reset `priv_out` is 3 and every other output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ret_req | input | 1 | Return request, one cycle |
| ret_is_mret | input | 1 | 1 = machine return, 0 = supervisor return |
| cur_priv | input | 2 | Current privilege level |
| status_in | input | XLEN | Current machine status word |
| mepc_in | input | XLEN | Saved machine exception PC |
| sepc_in | input | XLEN | Saved supervisor exception PC |
| has_compressed | input | 1 | Compressed instructions enabled |
| ret_done | output | 1 | Result valid pulse |
| status_out | output | XLEN | Updated status word |
| priv_out | output | 2 | Privilege to resume in |
| target_pc | output | XLEN | Resume address |
| exc_illegal | output | 1 | Illegal-instruction exception |
| exc_misaligned | output | 1 | Misaligned-target exception |
| exc_cause | output | 4 | Exception cause code |

## Verification
Every result of this block is registered exactly once. A wrong legality decision, a swapped level select or a mis-wired stack bit therefore appears on the outputs in the very cycle of `ret_done` that follows the faulty request. The sweep covers every combination of return kind, current privilege, compressed flag, saved privilege value, previous-enable bit and low address bits. Each combination is run on a status word whose other bits are scrambled, so a disturbed neighbouring bit or a wrongly chosen privilege shows up against the expected value at once. Idle cycles with changing inputs follow the requests, and any leak of those inputs into the outputs is visible on the first cycle it happens.

// File: rtl/trp_pkg.sv
package trp_pkg;
  localparam int unsigned PRIV_W  = 2;
  localparam int unsigned CAUSE_W = 4;

  localparam logic [PRIV_W-1:0] PRIV_USER  = 2'd0;
  localparam logic [PRIV_W-1:0] PRIV_SUPV  = 2'd1;
  localparam logic [PRIV_W-1:0] PRIV_RSVD  = 2'd2;
  localparam logic [PRIV_W-1:0] PRIV_MACH  = 2'd3;

  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL  = 4'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_MISALIGN = 4'd0;

  // status word field positions (decoded by neighbouring blocks)
  localparam int unsigned POS_SIE    = 1;
  localparam int unsigned POS_MIE    = 3;
  localparam int unsigned POS_SPIE   = 5;
  localparam int unsigned POS_MPIE   = 7;
  localparam int unsigned POS_SPP    = 8;
  localparam int unsigned POS_MPP_LO = 11;
  localparam int unsigned POS_MPP_HI = 12;
endpackage

// File: rtl/trp_priv_check.sv
module trp_priv_check
  import trp_pkg::*;
(
  input  logic              is_mret,
  input  logic [PRIV_W-1:0] cur_priv,
  input  logic [1:0]        saved_mpp,
  input  logic              saved_spp,
  output logic              illegal,
  output logic [PRIV_W-1:0] resume_priv
);
  logic [PRIV_W-1:0] req_level;
  logic [PRIV_W-1:0] mpp_mapped;

  always_comb begin
    req_level = is_mret ? PRIV_MACH : PRIV_SUPV;
    illegal   = (cur_priv < req_level);
  end

  always_comb begin
    mpp_mapped = (saved_mpp == PRIV_RSVD) ? PRIV_USER : saved_mpp;
    if (is_mret) resume_priv = mpp_mapped;
    else         resume_priv = {1'b0, saved_spp};
  end
endmodule

// File: rtl/trp_target_sel.sv
module trp_target_sel #(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned ALIGN_BITS = 2
) (
  input  logic            is_mret,
  input  logic [XLEN-1:0] mepc,
  input  logic [XLEN-1:0] sepc,
  input  logic            has_compressed,
  output logic [XLEN-1:0] target,
  output logic            misaligned
);
  always_comb target = is_mret ? mepc : sepc;

  generate
    if (ALIGN_BITS == 0) begin : g_no_align
      assign misaligned = 1'b0;
    end else begin : g_align
      logic [ALIGN_BITS-1:0] low_bits;
      assign low_bits   = target[ALIGN_BITS-1:0];
      assign misaligned = !has_compressed && (low_bits != '0);
    end
  endgenerate
endmodule

// File: rtl/trp_status_pop.sv
module trp_status_pop
  import trp_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            is_mret,
  input  logic [XLEN-1:0] status_in,
  output logic [XLEN-1:0] status_next
);
  generate
    for (genvar i = 0; i < XLEN; i++) begin : g_bit
      if (i == POS_MIE) begin : g_mie
        assign status_next[i] = is_mret ? status_in[POS_MPIE] : status_in[i];
      end else if (i == POS_SIE) begin : g_sie
        assign status_next[i] = is_mret ? status_in[i] : status_in[POS_SPIE];
      end else if (i == POS_MPIE || i == POS_MPP_LO || i == POS_MPP_HI) begin : g_mclr
        assign status_next[i] = is_mret ? 1'b0 : status_in[i];
      end else if (i == POS_SPIE || i == POS_SPP) begin : g_sclr
        assign status_next[i] = is_mret ? status_in[i] : 1'b0;
      end else begin : g_keep
        assign status_next[i] = status_in[i];
      end
    end
  endgenerate
endmodule

// File: rtl/trap_return_seq.sv
module trap_return_seq
  import trp_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ret_req,
  input  logic            ret_is_mret,
  input  logic [1:0]      cur_priv,
  input  logic [XLEN-1:0] status_in,
  input  logic [XLEN-1:0] mepc_in,
  input  logic [XLEN-1:0] sepc_in,
  input  logic            has_compressed,
  output logic            ret_done,
  output logic [XLEN-1:0] status_out,
  output logic [1:0]      priv_out,
  output logic [XLEN-1:0] target_pc,
  output logic            exc_illegal,
  output logic            exc_misaligned,
  output logic [3:0]      exc_cause
);
  logic              illegal_w;
  logic              mis_raw_w;
  logic              mis_w;
  logic              exc_w;
  logic [PRIV_W-1:0] resume_priv_w;
  logic [XLEN-1:0]   target_w;
  logic [XLEN-1:0]   popped_w;

  logic [XLEN-1:0]    status_n;
  logic [PRIV_W-1:0]  priv_n;
  logic [CAUSE_W-1:0] cause_n;

  logic               done_q;
  logic [XLEN-1:0]    status_q;
  logic [PRIV_W-1:0]  priv_q;
  logic [XLEN-1:0]    target_q;
  logic               ill_q;
  logic               mis_q;
  logic [CAUSE_W-1:0] cause_q;

  trp_priv_check u_priv (
    .is_mret     (ret_is_mret),
    .cur_priv    (cur_priv),
    .saved_mpp   (status_in[POS_MPP_HI:POS_MPP_LO]),
    .saved_spp   (status_in[POS_SPP]),
    .illegal     (illegal_w),
    .resume_priv (resume_priv_w)
  );

  trp_target_sel #(.XLEN(XLEN), .ALIGN_BITS(2)) u_target (
    .is_mret        (ret_is_mret),
    .mepc           (mepc_in),
    .sepc           (sepc_in),
    .has_compressed (has_compressed),
    .target         (target_w),
    .misaligned     (mis_raw_w)
  );

  trp_status_pop #(.XLEN(XLEN)) u_pop (
    .is_mret     (ret_is_mret),
    .status_in   (status_in),
    .status_next (popped_w)
  );

  // next-state
  always_comb begin
    mis_w = mis_raw_w && !illegal_w;
    exc_w = illegal_w || mis_w;
    if (exc_w) begin
      status_n = status_in;
      priv_n   = cur_priv;
    end else begin
      status_n = popped_w;
      priv_n   = resume_priv_w;
    end
    if (illegal_w)  cause_n = CAUSE_ILLEGAL;
    else if (mis_w) cause_n = CAUSE_MISALIGN;
    else            cause_n = '0;
  end

  // registers, data loaded only on a request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      status_q <= '0;
      priv_q   <= PRIV_MACH;
      target_q <= '0;
      ill_q    <= 1'b0;
      mis_q    <= 1'b0;
      cause_q  <= '0;
    end else begin
      done_q <= ret_req;
      if (ret_req) begin
        status_q <= status_n;
        priv_q   <= priv_n;
        target_q <= target_w;
        ill_q    <= illegal_w;
        mis_q    <= mis_w;
        cause_q  <= cause_n;
      end
    end
  end

  assign ret_done       = done_q;
  assign status_out     = status_q;
  assign priv_out       = priv_q;
  assign target_pc      = target_q;
  assign exc_illegal    = ill_q;
  assign exc_misaligned = mis_q;
  assign exc_cause      = cause_q;

  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_req |=> ret_done);
  // R1
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_req |=> !ret_done);
  // R2
  mret_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_req && ret_is_mret && (cur_priv != 2'd3) |=> exc_illegal && (exc_cause == 4'd2));
  // R2
  sret_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_req && !ret_is_mret && (cur_priv == 2'd0) |=> exc_illegal && (exc_cause == 4'd2));
  // R3
  target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_req |=> target_pc == ($past(ret_is_mret) ? $past(mepc_in) : $past(sepc_in)));
  // R4
  exc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({exc_illegal, exc_misaligned}));
  // R4
  compressed_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_req && has_compressed |=> !exc_misaligned);
  // R5
  exc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_done && (exc_illegal || exc_misaligned) |->
      (status_out == $past(status_in)) && (priv_out == $past(cur_priv)));
  // R8
  no_rsvd_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_done && !exc_illegal && !exc_misaligned |-> priv_out != 2'd2);
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_req |=> $stable(status_out) && $stable(priv_out) && $stable(target_pc)
                 && $stable(exc_cause));
endmodule

// File: tb/trap_return_seq_bench.sv
`timescale 1ns/1ps
module trap_return_seq_bench;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            ret_req;
  logic            ret_is_mret;
  logic [1:0]      cur_priv;
  logic [XLEN-1:0] status_in;
  logic [XLEN-1:0] mepc_in;
  logic [XLEN-1:0] sepc_in;
  logic            has_compressed;
  logic            ret_done;
  logic [XLEN-1:0] status_out;
  logic [1:0]      priv_out;
  logic [XLEN-1:0] target_pc;
  logic            exc_illegal;
  logic            exc_misaligned;
  logic [3:0]      exc_cause;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  trap_return_seq #(.XLEN(XLEN)) u_trap_return_seq (
    .clk(clk), .rst_n(rst_n), .ret_req(ret_req), .ret_is_mret(ret_is_mret),
    .cur_priv(cur_priv), .status_in(status_in), .mepc_in(mepc_in),
    .sepc_in(sepc_in), .has_compressed(has_compressed), .ret_done(ret_done),
    .status_out(status_out), .priv_out(priv_out), .target_pc(target_pc),
    .exc_illegal(exc_illegal), .exc_misaligned(exc_misaligned),
    .exc_cause(exc_cause)
  );

  task automatic check(input string req, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [XLEN-1:0] st, pc_sel, e_st, hold_st, hold_pc;
    logic [1:0]      e_pr, hold_pr;
    logic            e_ill, e_mis;
    int              idx;
    rst_n = 1'b0; ret_req = 1'b0; ret_is_mret = 1'b0; cur_priv = 2'd0;
    status_in = '0; mepc_in = '0; sepc_in = '0; has_compressed = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 reset priv", {30'd0, priv_out}, 32'd3);
    check("R10 reset status", status_out, '0);
    check("R10 reset pc", target_pc, '0);
    check("R1 reset done", {31'd0, ret_done}, '0);
    check("R10 reset flags", {26'd0, exc_illegal, exc_misaligned, exc_cause}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    idx = 0;
    for (int k = 0; k < 2; k++)
    for (int cp = 0; cp < 4; cp++)
    for (int hc = 0; hc < 2; hc++)
    for (int pp = 0; pp < 4; pp++)
    for (int pie = 0; pie < 2; pie++)
    for (int lo = 0; lo < 4; lo++) begin
      idx++;
      st = 32'h9E37_79B9 * (idx + 7);
      if (k == 1) begin
        st[12:11] = pp[1:0]; st[7] = pie[0]; st[3] = ~pie[0];
      end else begin
        st[8] = pp[0]; st[5] = pie[0]; st[1] = ~pie[0];
      end
      ret_is_mret    = k[0];
      cur_priv       = cp[1:0];
      has_compressed = hc[0];
      status_in      = st;
      mepc_in        = {(32'h8000_1000 + 32'(idx)) >> 2, 2'b00} | (k == 1 ? 32'(lo) : 32'(3 - lo));
      sepc_in        = {(32'h4000_2000 + 32'(idx)) >> 2, 2'b00} | (k == 0 ? 32'(lo) : 32'(3 - lo));
      ret_req        = 1'b1;
      // expected model
      pc_sel = (k == 1) ? mepc_in : sepc_in;
      e_ill  = (k == 1) ? (cp != 3) : (cp == 0);
      e_mis  = !e_ill && (hc == 0) && (pc_sel[1:0] != 2'b00);
      e_st   = st;
      e_pr   = cp[1:0];
      if (!e_ill && !e_mis) begin
        if (k == 1) begin
          e_st[3] = st[7]; e_st[7] = 1'b0; e_st[12:11] = 2'b00;
          e_pr = (pp == 2) ? 2'd0 : pp[1:0];
        end else begin
          e_st[1] = st[5]; e_st[5] = 1'b0; e_st[8] = 1'b0;
          e_pr = {1'b0, pp[0]};
        end
      end
      @(negedge clk);
      ret_req = 1'b0;
      check("R1 done", {31'd0, ret_done}, 32'd1);
      check("R3 target", target_pc, pc_sel);
      check("R2 illegal", {31'd0, exc_illegal}, {31'd0, e_ill});
      check("R4 misaligned", {31'd0, exc_misaligned}, {31'd0, e_mis});
      check("R2/R4 cause", {28'd0, exc_cause}, e_ill ? 32'd2 : 32'd0);
      if (e_ill || e_mis) begin
        check("R5 status kept", status_out, e_st);
        check("R5 priv kept", {30'd0, priv_out}, {30'd0, e_pr});
      end else if (k == 1) begin
        check("R6 mret status", status_out, e_st);
        check("R8 mret priv", {30'd0, priv_out}, {30'd0, e_pr});
      end else begin
        check("R7 sret status", status_out, e_st);
        check("R9 sret priv", {30'd0, priv_out}, {30'd0, e_pr});
      end
      // R10 hold across idle cycles with moving inputs
      if ((idx % 16) == 0) begin
        hold_st = status_out; hold_pr = priv_out; hold_pc = target_pc;
        status_in = ~status_in; mepc_in = ~mepc_in; sepc_in = ~sepc_in;
        cur_priv = ~cur_priv; ret_is_mret = ~ret_is_mret;
        repeat (2) @(negedge clk);
        check("R1 no done when idle", {31'd0, ret_done}, '0);
        check("R10 status hold", status_out, hold_st);
        check("R10 priv hold", {30'd0, priv_out}, {30'd0, hold_pr});
        check("R10 pc hold", target_pc, hold_pc);
      end
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule